// File: doc/BRIEF.md
# QRSS Loopback Self-Test Controller

This block runs a built-in self test over the digital path of a T1 line interface. Once the host starts a test, the block sends a quasi-random test stream one bit per bit period toward the transmit side. It also watches the stream that returns through the loopback with a self-synchronizing pattern detector. The detector first fills its own shift register from the received bits. After that it predicts every following bit and declares lock when a long run of its predictions all match.

A host register interface holds the host-mode enable, the start bit and three sticky result flags. A test-status output goes high when a test starts and drops only when the detector locks, so a low level means the test passed. Lock also sets the flags and pulls an active-low interrupt low. If lock does not come within a bounded number of bit periods, a timeout ends the test: the status output stays high and no flag is set. All sequencing advances only in clock cycles where the bit-period enable is high.

Top module: `qrss_selftest`

## Requirements
- R1: A write to address 0 stores bit 1 as the host-mode enable and requests a start with bit 0. The start is accepted only if bit 1 of the same write is 1. In any other case the request is ignored: no test runs, the busy bit (bit 0 read from address 0) stays 0 and `test_stat` keeps its value.
- R2: In the cycle after an accepted start, `test_stat` is 1 and the busy bit is 1. Both are 0 after reset.
- R3: The generator is a 20-bit shift register with feedback x^20 + x^17 + 1, loaded with `SEED` at start. It emits the register's oldest bit first and advances once per bit period. Stream bits 0 to 19 are therefore the `SEED` bits, most significant first; with the default seed they alternate 1,0,…, and bits 20 to 36 are all 1. `tx_bit` is 0 while no test runs.
- R4: An emitted bit is forced to 1 whenever the 14 register bits that follow it are all zero. As a result `tx_bit` never shows more than 14 zeros in a row, and 14-zero runs do occur.
- R5: The detector loads 20 received bits and then compares each further received bit with its prediction. It declares lock after 64 matches in a row. With a zero-delay loopback, lock takes effect on the 84th enabled clock edge after the start edge. Lock is also reached through a loopback delay.
- R6: A mismatch before lock discards the detector state and restarts the 20-bit load. A single bit error during the match phase therefore delays lock past the 84th bit period.
- R7: On lock, in the same cycle, `test_stat` goes to 0, busy goes to 0, and three flags are set: address 1 bit 0 (transmit pattern active), address 2 bit 0 (pattern detected) and address 2 bit 1 (self test passed). `irq_n` goes low.
- R8: If `TIMEOUT` bit periods pass without lock, busy goes to 0, `test_stat` stays 1 and no flag is set. A correct receive stream after that has no effect.
- R9: The flags stay set until cleared. Writing 1 to a flag bit at address 1 or 2 clears that bit, and writing 0 has no effect. `irq_n` returns high once all three flags are clear.
- R10: An accepted start during a running test restarts the generator from `SEED` and resets the detector and the timeout count, so lock comes 84 bit periods after the second start.
- R11: In cycles where `bit_en` is low, the generator, detector and timeout count hold, so all of these intervals count bit periods and not clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-period enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 transmit status, 2 pattern status) |
| reg_wdata | input | 2 | Register write data |
| reg_rdata | output | 2 | Register read data for `reg_addr` (combinational) |
| tx_bit | output | 1 | Test stream toward the transmit path |
| rx_bit | input | 1 | Looped-back receive stream |
| irq_n | output | 1 | Active-low interrupt, low while any flag is set |
| test_stat | output | 1 | High during a test and after a failed one, low after a pass |

## Verification
An accepted start shows on `test_stat` and busy one clock edge after the write edge. Stream bit k sits on `tx_bit` after the k-th enabled edge following the start. With a zero-delay loopback, lock, the flags and `irq_n` all change on the 84th enabled edge, and a timeout ends the test on edge `TIMEOUT`. The bench counts these edges from the write, samples at falling edges, and checks the status output one edge before and one edge after each due point. Where the loopback delay or a reseed makes the exact edge depend on the pattern, it checks a lower bound with a fixed edge count and an upper bound with a polling limit.

// File: rtl/qrss_selftest.sv
`timescale 1ns/1ps
module qrss_selftest #(
  parameter logic [19:0] SEED     = 20'hAAAAA,
  parameter int          LOCK_RUN = 64,
  parameter int          ZERO_CAP = 14,
  parameter int          TIMEOUT  = 65536
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [1:0] reg_wdata,
  output logic [1:0] reg_rdata,
  output logic       tx_bit,
  input  logic       rx_bit,
  output logic       irq_n,
  output logic       test_stat
);
  localparam int W      = 20;
  localparam int TAP    = 17;
  localparam int SCNT_W = $clog2(W + 1);
  localparam int RUN_W  = $clog2(LOCK_RUN + 1);
  localparam int TO_W   = $clog2(TIMEOUT + 2);
  localparam int ZW     = $clog2(ZERO_CAP + 2);

  logic [W-1:0]      gen_q, det_q;
  logic [SCNT_W-1:0] seed_cnt;
  logic [RUN_W-1:0]  run_cnt;
  logic [TO_W-1:0]   to_cnt;
  logic              running_q, host_q, stat_q;
  logic              flag_txq, flag_det, flag_pass;
  logic [ZERO_CAP:0] pred;

  wire ctrl_wr   = reg_wr && reg_addr == 2'd0;
  wire start_go  = ctrl_wr && reg_wdata[0] && reg_wdata[1];
  wire step      = running_q && bit_en;
  wire gen_force = ~|gen_q[W-2 -: ZERO_CAP];
  wire gen_fb    = gen_q[W-1] ^ gen_q[TAP-1];

  assign tx_bit    = running_q & (gen_q[W-1] | gen_force);
  assign test_stat = stat_q;
  assign irq_n     = ~(flag_txq | flag_det | flag_pass);

  genvar k;
  for (k = 0; k <= ZERO_CAP; k++) begin : g_pred
    assign pred[k] = det_q[W-1-k] ^ det_q[TAP-1-k];
  end

  wire exp_bit     = pred[0] | ~|pred[ZERO_CAP:1];
  wire tracking    = seed_cnt == SCNT_W'(W);
  wire match       = rx_bit == exp_bit;
  wire lock_now    = step && tracking && match && run_cnt == RUN_W'(LOCK_RUN - 1);
  wire timeout_now = step && !lock_now && (TIMEOUT > 0) && to_cnt == TO_W'(TIMEOUT - 1);
  wire lock_ok     = lock_now && !start_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q     <= SEED;
      det_q     <= '0;
      seed_cnt  <= '0;
      run_cnt   <= '0;
      to_cnt    <= '0;
      running_q <= 1'b0;
      host_q    <= 1'b0;
      stat_q    <= 1'b0;
    end else begin
      if (ctrl_wr) host_q <= reg_wdata[1];
      if (start_go) begin
        gen_q     <= SEED;
        det_q     <= '0;
        seed_cnt  <= '0;
        run_cnt   <= '0;
        to_cnt    <= '0;
        running_q <= 1'b1;
        stat_q    <= 1'b1;
      end else if (step) begin
        gen_q  <= {gen_q[W-2:0], gen_fb};
        to_cnt <= to_cnt + 1'b1;
        if (!tracking) begin
          det_q    <= {det_q[W-2:0], rx_bit};
          seed_cnt <= seed_cnt + 1'b1;
        end else if (match) begin
          det_q   <= {det_q[W-2:0], pred[0]};
          run_cnt <= run_cnt + 1'b1;
        end else begin
          seed_cnt <= '0;
          run_cnt  <= '0;
        end
        if (lock_now) begin
          running_q <= 1'b0;
          stat_q    <= 1'b0;
        end else if (timeout_now) begin
          running_q <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_txq  <= 1'b0;
      flag_det  <= 1'b0;
      flag_pass <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == 2'd1 && reg_wdata[0]) flag_txq  <= 1'b0;
      if (reg_wr && reg_addr == 2'd2 && reg_wdata[0]) flag_det  <= 1'b0;
      if (reg_wr && reg_addr == 2'd2 && reg_wdata[1]) flag_pass <= 1'b0;
      if (lock_ok) begin
        flag_txq  <= 1'b1;
        flag_det  <= 1'b1;
        flag_pass <= 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {host_q, running_q};
      2'd1:    reg_rdata = {1'b0, flag_txq};
      2'd2:    reg_rdata = {flag_pass, flag_det};
      default: reg_rdata = 2'b00;
    endcase
  end

  logic [ZW-1:0] zrun;
  always_ff @(posedge clk) begin
    if (!rst_n || start_go) zrun <= '0;
    else if (step) zrun <= tx_bit ? '0 : ((zrun == '1) ? zrun : zrun + 1'b1);
  end

  // R4
  zero_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(zrun) <= ZERO_CAP);

  // R1
  host_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && reg_wdata[0] && !reg_wdata[1] && !running_q |=> !running_q);

  // R2
  start_raises_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> test_stat && running_q);

  // R7
  lock_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(test_stat) |-> !irq_n && flag_pass && flag_det && flag_txq && !running_q);

  // R9
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> $past(reg_wr && reg_addr != 2'd0));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en && !start_go |=> $stable(gen_q) && $stable(to_cnt));
endmodule

// File: tb/test_qrss_selftest.sv
`timescale 1ns/1ps
module test_qrss_selftest;
  logic       clk = 1'b0, rst_n = 1'b0, bit_en = 1'b1, reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0, reg_wdata = 2'd0;
  logic [1:0] reg_rdata;
  logic       tx_bit, rx_bit, irq_n, test_stat;
  int         checks = 0, errors = 0, en_div = 1, cyc = 0, dly = 0;
  logic       flip = 1'b0, stuck0 = 1'b0;
  logic [31:0] pipe = '0;
  bit         done = 0;

  always #2 clk = ~clk;

  qrss_selftest #(.TIMEOUT(1000)) i_qrss_selftest (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_bit(tx_bit), .rx_bit(rx_bit), .irq_n(irq_n), .test_stat(test_stat));

  always @(negedge clk) begin
    cyc = cyc + 1;
    bit_en = (cyc % en_div) == 0;
  end
  always @(posedge clk) if (bit_en) pipe <= {pipe[30:0], tx_bit};
  always_comb rx_bit = stuck0 ? 1'b0 : ((dly == 0 ? tx_bit : pipe[dly-1]) ^ flip);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic wait_lock(input int maxc, output int n);
    n = 0;
    while (test_stat && n < maxc) begin tick(1); n++; end
  endtask

  task automatic clear_all();
    wr(2'd1, 2'b01);
    wr(2'd2, 2'b11);
  endtask

  task automatic t_reset();
    int v;
    chk("R2 reset test_stat", int'(test_stat), 0);
    chk("R9 reset irq_n", int'(irq_n), 1);
    chk("R3 idle tx_bit", int'(tx_bit), 0);
    rd(2'd0, v); chk("R2 reset control", v, 0);
    rd(2'd2, v); chk("R9 reset pattern flags", v, 0);
  endtask

  task automatic t_host_gate();
    int v;
    wr(2'd0, 2'b01);
    rd(2'd0, v); chk("R1 start without host mode busy", v, 0);
    chk("R1 start without host mode test_stat", int'(test_stat), 0);
    tick(100);
    chk("R1 no lock without host mode", int'(test_stat), 0);
    rd(2'd2, v); chk("R1 no flags without host mode", v, 0);
    chk("R1 tx idle", int'(tx_bit), 0);
  endtask

  task automatic t_basic_lock();
    int v, bad;
    bad = 0;
    wr(2'd0, 2'b11);
    chk("R2 test_stat after start", int'(test_stat), 1);
    rd(2'd0, v); chk("R2 busy and host after start", v, 3);
    for (int k = 0; k < 83; k++) begin
      if (k < 20 && tx_bit != ((k % 2) == 0)) bad++;
      if (k >= 20 && k <= 36 && tx_bit != 1'b1) bad++;
      tick(1);
    end
    chk("R3 seed order and early stream bits", bad, 0);
    chk("R5 no lock before 84th bit", int'(test_stat), 1);
    tick(1);
    chk("R5 lock on 84th bit test_stat", int'(test_stat), 0);
    chk("R7 irq_n low on lock", int'(irq_n), 0);
    rd(2'd1, v); chk("R7 transmit pattern flag", v, 1);
    rd(2'd2, v); chk("R7 detected and passed flags", v, 3);
    rd(2'd0, v); chk("R7 busy cleared on lock", v, 2);
  endtask

  task automatic t_clear();
    int v;
    tick(50);
    rd(2'd2, v); chk("R9 flags sticky", v, 3);
    wr(2'd2, 2'b01);
    rd(2'd2, v); chk("R9 clear detected only", v, 2);
    chk("R9 irq_n still low", int'(irq_n), 0);
    wr(2'd1, 2'b00);
    rd(2'd1, v); chk("R9 write 0 no effect", v, 1);
    wr(2'd1, 2'b01);
    rd(2'd1, v); chk("R9 clear transmit flag", v, 0);
    chk("R9 irq_n low while pass set", int'(irq_n), 0);
    wr(2'd2, 2'b10);
    rd(2'd2, v); chk("R9 clear pass flag", v, 0);
    chk("R9 irq_n released", int'(irq_n), 1);
  endtask

  task automatic t_restart();
    wr(2'd0, 2'b11);
    tick(50);
    wr(2'd0, 2'b11);
    tick(83);
    chk("R10 restart delays lock", int'(test_stat), 1);
    tick(1);
    chk("R10 lock 84 bits after restart", int'(test_stat), 0);
    clear_all();
  endtask

  task automatic t_error();
    int n, v;
    wr(2'd0, 2'b11);
    tick(40);
    flip = 1'b1;
    tick(1);
    flip = 1'b0;
    tick(43);
    chk("R6 bit error delays lock", int'(test_stat), 1);
    wait_lock(400, n);
    chk("R6 relock after error", int'(test_stat), 0);
    rd(2'd2, v); chk("R6 flags after relock", v, 3);
    clear_all();
  endtask

  task automatic t_delay();
    int n, v;
    dly = 5;
    wr(2'd0, 2'b11);
    wait_lock(400, n);
    chk("R5 lock through delayed loopback", int'(test_stat), 0);
    rd(2'd2, v); chk("R5 flags through delayed loopback", v, 3);
    dly = 0;
    clear_all();
  endtask

  task automatic t_slow();
    int v;
    en_div = 3;
    wr(2'd0, 2'b11);
    tick(240);
    chk("R11 no lock before 84 enabled bits", int'(test_stat), 1);
    rd(2'd0, v); chk("R11 busy while enable sparse", v, 3);
    tick(20);
    chk("R11 lock after 84 enabled bits", int'(test_stat), 0);
    en_div = 1;
    tick(3);
    clear_all();
  endtask

  task automatic t_timeout();
    int v, run, maxrun;
    run = 0; maxrun = 0;
    stuck0 = 1'b1;
    wr(2'd0, 2'b11);
    for (int k = 0; k < 999; k++) begin
      if (tx_bit == 1'b0) run++; else run = 0;
      if (run > maxrun) maxrun = run;
      tick(1);
    end
    chk("R4 longest zero run is 14", maxrun, 14);
    rd(2'd0, v); chk("R8 busy before timeout", v, 3);
    tick(1);
    rd(2'd0, v); chk("R8 busy cleared at timeout", v, 2);
    chk("R8 test_stat stays high", int'(test_stat), 1);
    rd(2'd2, v); chk("R8 no pattern flags", v, 0);
    rd(2'd1, v); chk("R8 no transmit flag", v, 0);
    chk("R8 irq_n stays high", int'(irq_n), 1);
    stuck0 = 1'b0;
    tick(200);
    chk("R8 no late lock", int'(test_stat), 1);
    rd(2'd2, v); chk("R8 no late flags", v, 0);
    chk("R3 tx idle after test", int'(tx_bit), 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_host_gate();
    t_basic_lock();
    t_clear();
    t_restart();
    t_error();
    t_delay();
    t_slow();
    t_timeout();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule